// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Front End

This block is the host-facing register set for one channel of a storage bus-master DMA engine. It holds a command byte (run bit and transfer direction), a status byte (busy, error and interrupt flags) and a 32-bit pointer to the descriptor table. The host reaches the registers through a small byte-addressed port that accepts 1-, 2- or 4-byte reads and writes. On the engine side the block issues a single-cycle launch pulse, presents the direction and the current table pointer, and accepts done, error and interrupt strobes.

Turning the run bit on launches a transfer unless one is already under way. Turning it off never cuts a transfer short: the engine always runs to completion, and the busy flag falls only when the engine reports done. Writes that leave the run bit unchanged only refresh the stored command byte.

The register window is 8 bytes: command at offset 0, status at offset 2, descriptor pointer at offsets 4 to 7. All other offsets read as zero and ignore writes. The access size code on `host_size` is 0 for one byte, 1 for two bytes and 2 or 3 for four bytes.

Top module: `bmdma_regs`

## Requirements
- R1: The command byte at offset 0 keeps only its run bit (bit 0) and direction bit (bit 3); reading it returns every other bit as zero, and `eng_dir` follows bit 3.
- R2: A command write whose run bit equals the stored run bit issues no launch pulse and leaves `active` unchanged; only the stored byte is refreshed.
- R3: A command write that changes the run bit from 0 to 1 while `active` is low sets `active` and raises `eng_start` for exactly one cycle, both visible in the cycle after the write.
- R4: A command write that changes the run bit from 1 to 0 does not clear `active` or pulse `eng_start`; `active` falls only in the cycle after `eng_done` is high.
- R5: A 0-to-1 run-bit change while `active` is high, with `eng_done` low in that cycle, issues no launch pulse.
- R6: When a 0-to-1 run-bit change and `eng_done` arrive in the same cycle, a new launch pulse is issued and `active` stays high.
- R7: A write to the pointer at offset 4+k (k = 0..3) replaces only byte lanes k up to k+size-1 with the low bytes of `host_wdata`; lanes above 3 are dropped and the remaining lanes keep their values.
- R8: Bits 1:0 of the descriptor pointer always read as zero, whatever was written.
- R9: Every pointer write copies the new pointer value to `eng_cur_addr` in the next cycle; without a pointer write `eng_cur_addr` holds its value.
- R10: A read of the pointer at offset 4+k returns the pointer shifted right by 8*k bits, masked to the access width.
- R11: Status bit 0 is `active` and cannot be written; bit 1 (error) and bit 2 (interrupt) are set by `eng_err` and `eng_irq`, cleared by writing 1 to that bit at offset 2, and a set in the same cycle as a clear wins.
- R12: A synchronous active-high reset clears the command, status, pointer and current pointer to zero and drops `eng_start`.
- R13: Read data appears on `host_rdata` in the cycle after `host_rd_en`, masked to the access width, holds until the next read, and offsets 1, 3 and 5-7 beyond the pointer lanes read as defined by R10 or as zero for the unused bytes 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 3 | Byte offset inside the register window |
| host_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| host_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| host_rdata | output | 32 | Registered read data |
| eng_start | output | 1 | One-cycle launch pulse to the transfer engine |
| eng_dir | output | 1 | Transfer direction from the command byte |
| eng_cur_addr | output | 32 | Current descriptor pointer for the engine |
| eng_done | input | 1 | Engine completion strobe |
| eng_err | input | 1 | Engine error strobe |
| eng_irq | input | 1 | Engine interrupt strobe |
| active | output | 1 | Transfer in progress flag |

## Verification
The sharpest collision is a run-bit rising write arriving in the same cycle as the engine's done strobe: the bench lowers the run bit during a transfer, then drives the re-enabling write and `eng_done` on the same clock, and expects a fresh launch pulse with `active` staying high. A second collision is an engine error or interrupt strobe landing on the same cycle as the host's write-one-to-clear of that flag, which must leave the flag set. Both are judged by the behavioural model, which is compared with the outputs on every clock, and by directed reads of the status byte.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  // Register window layout (byte offsets)
  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd2;

  // Command byte bit positions
  localparam int CMD_RUN_BIT = 0;
  localparam int CMD_DIR_BIT = 3;

  // Status byte bit positions
  localparam int STAT_ACT_BIT = 0;
  localparam int STAT_ERR_BIT = 1;
  localparam int STAT_IRQ_BIT = 2;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } acc_size_e;

  // Lane enable pattern for an access of the given size, starting at lane 0
  function automatic logic [3:0] size_lanes(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: size_lanes = 4'b0001;
      SZ_HALF: size_lanes = 4'b0011;
      default: size_lanes = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/bmdma_cmd_ctl.sv
module bmdma_cmd_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_run,
  input  logic wr_dir,
  input  logic eng_done,
  output logic run_q,
  output logic dir_q,
  output logic active_q,
  output logic start_pulse
);

  logic run_rise;
  logic launch;

  assign run_rise = wr_en && wr_run && !run_q;
  // A completing transfer frees the channel in the same cycle
  assign launch   = run_rise && (!active_q || eng_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= 1'b0;
      dir_q       <= 1'b0;
      active_q    <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      if (wr_en) begin
        run_q <= wr_run;
        dir_q <= wr_dir;
      end
      start_pulse <= launch;
      if (launch)
        active_q <= 1'b1;
      else if (eng_done)
        active_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bmdma_stat_flags.sv
module bmdma_stat_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flag_q
);

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_q[g] <= 1'b0;
      else if (set_i[g])
        flag_q[g] <= 1'b1;
      else if (clr_i[g])
        flag_q[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg #(
  parameter int PTR_W  = 32,
  parameter int ALIGN  = 2,
  localparam int NLANE  = PTR_W / 8,
  localparam int LANE_W = $clog2(NLANE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] lane,
  input  logic [1:0]        size,
  input  logic [PTR_W-1:0]  wdata,
  output logic [PTR_W-1:0]  base_q,
  output logic [PTR_W-1:0]  cur_q
);

  localparam logic [PTR_W-1:0] ALIGN_MASK = ~((PTR_W)'((1 << ALIGN) - 1));

  logic [3:0]       lanes_raw;
  logic [NLANE-1:0] lanes_en;
  logic [PTR_W-1:0] wdata_sh;
  logic [PTR_W-1:0] merged;

  assign lanes_raw = bmdma_pkg::size_lanes(size);
  assign lanes_en  = lanes_raw[NLANE-1:0] << lane;
  assign wdata_sh  = wdata << {lane, 3'b000};

  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    assign merged[8*j +: 8] = lanes_en[j] ? wdata_sh[8*j +: 8] : base_q[8*j +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (wr_en) begin
      base_q <= merged & ALIGN_MASK;
      cur_q  <= merged & ALIGN_MASK;
    end
  end

endmodule

// File: rtl/bmdma_rd_port.sv
module bmdma_rd_port #(
  parameter int PTR_W  = 32,
  localparam int NLANE  = PTR_W / 8,
  localparam int LANE_W = $clog2(NLANE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              sel_cmd,
  input  logic              sel_stat,
  input  logic              sel_ptr,
  input  logic [LANE_W-1:0] lane,
  input  logic [1:0]        size,
  input  logic [7:0]        cmd_byte,
  input  logic [7:0]        stat_byte,
  input  logic [PTR_W-1:0]  ptr,
  output logic [PTR_W-1:0]  rdata
);

  logic [3:0]       lanes_raw;
  logic [PTR_W-1:0] raw;
  logic [PTR_W-1:0] bitmask;

  assign lanes_raw = bmdma_pkg::size_lanes(size);

  for (genvar j = 0; j < NLANE; j++) begin : g_mask
    assign bitmask[8*j +: 8] = {8{lanes_raw[j]}};
  end

  always_comb begin
    raw = '0;
    if (sel_cmd)
      raw = (PTR_W)'(cmd_byte);
    else if (sel_stat)
      raw = (PTR_W)'(stat_byte);
    else if (sel_ptr)
      raw = ptr >> {lane, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= raw & bitmask;
  end

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int PTR_W  = 32,
  localparam int NLANE  = PTR_W / 8,
  localparam int LANE_W = $clog2(NLANE),
  localparam int WIN_AW = LANE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [WIN_AW-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [PTR_W-1:0]  host_wdata,
  output logic [PTR_W-1:0]  host_rdata,
  output logic              eng_start,
  output logic              eng_dir,
  output logic [PTR_W-1:0]  eng_cur_addr,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_irq,
  output logic              active
);

  import bmdma_pkg::*;

  logic             sel_cmd, sel_stat, sel_ptr;
  logic             run_q, dir_q;
  logic [1:0]       flag_set, flag_clr, flag_q;
  logic [7:0]       cmd_byte, stat_byte;
  logic [PTR_W-1:0] ptr_q;

  assign sel_cmd  = (host_addr == WIN_AW'(OFS_CMD));
  assign sel_stat = (host_addr == WIN_AW'(OFS_STAT));
  assign sel_ptr  = host_addr[WIN_AW-1];

  bmdma_cmd_ctl u_cmd (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (host_wr_en && sel_cmd),
    .wr_run     (host_wdata[CMD_RUN_BIT]),
    .wr_dir     (host_wdata[CMD_DIR_BIT]),
    .eng_done   (eng_done),
    .run_q      (run_q),
    .dir_q      (dir_q),
    .active_q   (active),
    .start_pulse(eng_start)
  );

  assign flag_set = {eng_irq, eng_err};
  assign flag_clr = {2{host_wr_en && sel_stat}} &
                    {host_wdata[STAT_IRQ_BIT], host_wdata[STAT_ERR_BIT]};

  bmdma_stat_flags #(.NFLAG(2)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .flag_q(flag_q)
  );

  bmdma_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .wr_en (host_wr_en && sel_ptr),
    .lane  (host_addr[LANE_W-1:0]),
    .size  (host_size),
    .wdata (host_wdata),
    .base_q(ptr_q),
    .cur_q (eng_cur_addr)
  );

  always_comb begin
    cmd_byte = '0;
    cmd_byte[CMD_RUN_BIT] = run_q;
    cmd_byte[CMD_DIR_BIT] = dir_q;
    stat_byte = '0;
    stat_byte[STAT_ACT_BIT] = active;
    stat_byte[STAT_ERR_BIT] = flag_q[0];
    stat_byte[STAT_IRQ_BIT] = flag_q[1];
  end

  assign eng_dir = dir_q;

  bmdma_rd_port #(.PTR_W(PTR_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (host_rd_en),
    .sel_cmd  (sel_cmd),
    .sel_stat (sel_stat),
    .sel_ptr  (sel_ptr),
    .lane     (host_addr[LANE_W-1:0]),
    .size     (host_size),
    .cmd_byte (cmd_byte),
    .stat_byte(stat_byte),
    .ptr      (ptr_q),
    .rdata    (host_rdata)
  );

endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr_en,
  input logic             eng_start,
  input logic             eng_done,
  input logic             active,
  input logic [PTR_W-1:0] eng_cur_addr
);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);                                   // R3

  AST_START_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> active);                                       // R3

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (active && !eng_done) |=> active);                           // R4

  AST_ACTIVE_FALLS_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    ($fell(active) && !$past(rst)) |-> $past(eng_done));         // R4

  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    eng_cur_addr[1:0] == 2'b00);                                 // R8

  AST_CUR_ADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !host_wr_en |=> $stable(eng_cur_addr));                      // R9

endmodule

bind bmdma_regs bmdma_regs_chk #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_wr_en  (host_wr_en),
  .eng_start   (eng_start),
  .eng_done    (eng_done),
  .active      (active),
  .eng_cur_addr(eng_cur_addr)
);

// File: tb/bmdma_regs_tb.sv
`timescale 1ns/1ps
module bmdma_regs_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        eng_start, eng_dir, active;
  logic [31:0] eng_cur_addr;
  logic        eng_done = 1'b0, eng_err = 1'b0, eng_irq = 1'b0;

  int checks = 0;
  int failures = 0;
  bit model_live = 1'b0;

  always #2.5 clk = ~clk;

  bmdma_regs u_dut (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .eng_start(eng_start), .eng_dir(eng_dir),
    .eng_cur_addr(eng_cur_addr), .eng_done(eng_done), .eng_err(eng_err),
    .eng_irq(eng_irq), .active(active)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_run, m_dir, m_act, m_err, m_irq, m_pulse;
  logic [31:0] m_ptr, m_rdata;

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_dir = 0; m_act = 0; m_err = 0; m_irq = 0; m_pulse = 0;
      m_ptr = 0; m_rdata = 0;
      model_live = 1'b1;
    end else begin
      int off;
      off = int'(host_addr[1:0]);
      if (host_rd_en) begin
        logic [31:0] v;
        v = 0;
        if (host_addr == 3'd0) v = {28'd0, m_dir, 2'b00, m_run};
        else if (host_addr == 3'd2) v = {29'd0, m_irq, m_err, m_act};
        else if (host_addr[2]) v = m_ptr >> (8 * off);
        for (int b = 0; b < 4; b++) if (b >= nbytes(host_size)) v[8*b +: 8] = 8'h00;
        m_rdata = v;
      end
      m_pulse = 0;
      if (host_wr_en && host_addr == 3'd0) begin
        if (host_wdata[0] && !m_run && (!m_act || eng_done)) m_pulse = 1;
        m_run = host_wdata[0];
        m_dir = host_wdata[3];
      end
      if (m_pulse) m_act = 1;
      else if (eng_done) m_act = 0;
      if (eng_err) m_err = 1;
      else if (host_wr_en && host_addr == 3'd2 && host_wdata[1]) m_err = 0;
      if (eng_irq) m_irq = 1;
      else if (host_wr_en && host_addr == 3'd2 && host_wdata[2]) m_irq = 0;
      if (host_wr_en && host_addr[2]) begin
        for (int i = 0; i < nbytes(host_size); i++)
          if (off + i < 4) m_ptr[8*(off+i) +: 8] = host_wdata[8*i +: 8];
        m_ptr[1:0] = 2'b00;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, got, exp);
    end
  endtask

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (model_live && !rst) begin
      chk("R3", "eng_start", {31'd0, eng_start}, {31'd0, m_pulse});
      chk("R4", "active", {31'd0, active}, {31'd0, m_act});
      chk("R9", "eng_cur_addr", eng_cur_addr, m_ptr);
      chk("R1", "eng_dir", {31'd0, eng_dir}, {31'd0, m_dir});
      chk("R10", "host_rdata", host_rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [1:0] sz, input logic [31:0] d,
                    input bit done = 0);
    @(negedge clk);
    host_wr_en = 1; host_addr = a; host_size = sz; host_wdata = d; eng_done = done;
    @(negedge clk);
    host_wr_en = 0; eng_done = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    host_rd_en = 1; host_addr = a; host_size = sz;
    @(negedge clk);
    host_rd_en = 0;
    d = host_rdata;
  endtask

  task automatic strobe(input bit dn, input bit er, input bit iq);
    @(negedge clk);
    eng_done = dn; eng_err = er; eng_irq = iq;
    @(negedge clk);
    eng_done = 0; eng_err = 0; eng_irq = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 0;

    // R12: reset state
    chk("R12", "active after reset", {31'd0, active}, 32'd0);
    chk("R12", "cur_addr after reset", eng_cur_addr, 32'd0);
    rd(3'd0, 2'd0, r); chk("R12", "cmd after reset", r, 32'd0);
    rd(3'd2, 2'd0, r); chk("R12", "status after reset", r, 32'd0);
    rd(3'd4, 2'd2, r); chk("R12", "pointer after reset", r, 32'd0);

    // R1 + R3: write all ones, only run and dir survive; launch
    wr(3'd0, 2'd0, 32'h0000_00FF);
    chk("R3", "launch pulse", {31'd0, eng_start}, 32'd1);
    chk("R3", "active set", {31'd0, active}, 32'd1);
    @(negedge clk);
    chk("R3", "pulse one cycle", {31'd0, eng_start}, 32'd0);
    rd(3'd0, 2'd2, r); chk("R1", "cmd mask", r, 32'h09);

    // R2: same run bit, dir changes
    wr(3'd0, 2'd0, 32'h01);
    chk("R2", "no pulse same run", {31'd0, eng_start}, 32'd0);
    rd(3'd0, 2'd0, r); chk("R2", "cmd refreshed", r, 32'h01);

    // R4: stop does not abort
    wr(3'd0, 2'd0, 32'h00);
    chk("R4", "no pulse on stop", {31'd0, eng_start}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R4", "active held after stop", {31'd0, active}, 32'd1);

    // R5: restart while busy
    wr(3'd0, 2'd0, 32'h01);
    chk("R5", "no pulse while active", {31'd0, eng_start}, 32'd0);

    // R11: status write cannot touch active
    wr(3'd2, 2'd0, 32'h01);
    chk("R11", "active read-only", {31'd0, active}, 32'd1);

    // R4: done clears active
    strobe(1, 0, 0);
    chk("R4", "active cleared by done", {31'd0, active}, 32'd0);

    // R3 again, then R6 collision of restart with done
    wr(3'd0, 2'd0, 32'h00);
    wr(3'd0, 2'd0, 32'h09);
    chk("R3", "relaunch pulse", {31'd0, eng_start}, 32'd1);
    wr(3'd0, 2'd0, 32'h00);
    wr(3'd0, 2'd0, 32'h01, 1'b1);
    chk("R6", "pulse with done", {31'd0, eng_start}, 32'd1);
    chk("R6", "active stays", {31'd0, active}, 32'd1);
    strobe(1, 0, 0);

    // R11: error / interrupt flags
    strobe(0, 1, 1);
    rd(3'd2, 2'd0, r); chk("R11", "flags set", r, 32'h06);
    wr(3'd2, 2'd0, 32'h02);
    rd(3'd2, 2'd0, r); chk("R11", "error cleared", r, 32'h04);
    @(negedge clk);
    host_wr_en = 1; host_addr = 3'd2; host_size = 2'd0; host_wdata = 32'h04; eng_irq = 1;
    @(negedge clk);
    host_wr_en = 0; eng_irq = 0;
    rd(3'd2, 2'd0, r); chk("R11", "set beats clear", r, 32'h04);
    wr(3'd2, 2'd0, 32'h04);
    rd(3'd2, 2'd0, r); chk("R11", "irq cleared", r, 32'h00);

    // R7..R10: descriptor pointer
    wr(3'd4, 2'd2, 32'h1234_5677);
    chk("R9", "cur copy", eng_cur_addr, 32'h1234_5674);
    rd(3'd4, 2'd2, r); chk("R8", "low bits forced", r, 32'h1234_5674);
    wr(3'd6, 2'd0, 32'h0000_00AB);
    rd(3'd4, 2'd2, r); chk("R7", "byte lane 2", r, 32'h12AB_5674);
    wr(3'd7, 2'd1, 32'h0000_CDEF);
    rd(3'd4, 2'd2, r); chk("R7", "lane overflow dropped", r, 32'hEFAB_5674);
    wr(3'd4, 2'd1, 32'h0000_FFFF);
    rd(3'd4, 2'd2, r); chk("R8", "half write aligned", r, 32'hEFAB_FFFC);
    chk("R9", "cur follows", eng_cur_addr, 32'hEFAB_FFFC);
    rd(3'd5, 2'd0, r); chk("R10", "byte read off1", r, 32'h0000_00FF);
    rd(3'd6, 2'd1, r); chk("R10", "half read off2", r, 32'h0000_EFAB);
    rd(3'd7, 2'd2, r); chk("R10", "word read off3", r, 32'h0000_00EF);

    // R13: unused offset reads zero and data holds without a read
    rd(3'd1, 2'd2, r); chk("R13", "unused offset", r, 32'h0);
    wr(3'd3, 2'd2, 32'hFFFF_FFFF);
    chk("R13", "rdata holds", host_rdata, 32'h0);
    rd(3'd4, 2'd2, r); chk("R13", "unused write ignored", r, 32'hEFAB_FFFC);

    // R12: reset mid-run
    wr(3'd0, 2'd0, 32'h00);
    wr(3'd0, 2'd0, 32'h01);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R12", "active cleared by reset", {31'd0, active}, 32'd0);
    chk("R12", "cur cleared by reset", eng_cur_addr, 32'd0);
    rd(3'd0, 2'd0, r); chk("R12", "cmd cleared by reset", r, 32'd0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule